// File: doc/BRIEF.md
# Inner Label Parser and Egress Filter

This block sits in the receive path of a routing bridge, at transit or egress. It takes a byte stream that begins right after the inner source MAC address of a received data frame. From it the block works out whether the frame carries a 12-bit VLAN label, carries a 24-bit fine label, or is malformed. It pulls out the label and both pairs of priority and drop-eligibility bits. It then decides, for every output port, whether the frame may leave through that port and which C-VLAN the egressed native frame should carry.

Each port has a small table of label entries. Every entry is marked as either a VLAN entry or a fine-label entry. A frame can match only entries of its own kind, so the VLAN space and the fine-label space never mix. This holds even when the high part of a fine label is numerically equal to a VLAN ID configured on the port. Each port also has a tag-strip flag. Results are registered and stay on the outputs until the next start of frame.

Top module: `inner_label_filter`

## Requirements
- R1: An Ethertype of 0x8100 in the first two bytes (byte 0 most significant) gives class 1 (VLAN). An Ethertype of 0x893B gives class 2 (fine). Class 0 is unknown and class 3 is malformed.
- R2: Any other first Ethertype is decided on byte 1 as class 0. Label, priorities, permit mask, strip mask and C-VLAN outputs are then all zero, whatever bytes follow.
- R3: For a fine frame, if bytes 4 and 5 are not 0x893B, the frame is decided on byte 5 as class 3 and no port is permitted.
- R4: A frame whose end marker arrives before the label area is complete (4 bytes for VLAN, 8 bytes for fine, or before the Ethertype is known) is class 3, decided on the byte carrying the end marker.
- R5: The transport priority is bits 15:13 and the transport DEI is bit 12 of the 16-bit word in bytes 2 and 3, in both formats.
- R6: For a fine frame the label is {word(2,3)[11:0], word(6,7)[11:0]}, and the native priority and DEI are bits 15:13 and bit 12 of word(6,7). For a VLAN frame the label output is the 12-bit VID, zero-extended, and the native priority and DEI equal the transport ones.
- R7: A fine frame is permitted on a port only if a valid fine entry of that port holds the identical 24-bit label. VLAN entries never match fine frames, and fine entries never match VLAN frames.
- R8: A VLAN frame is permitted on a port that has a valid VLAN entry with the same 12-bit ID. Its egress C-VLAN on that port is the frame's own VID.
- R9: For a fine frame, a permitted port's egress C-VLAN is the C-VLAN field of the lowest-numbered matching slot. Ports that are not permitted show C-VLAN 0.
- R10: The strip mask is the per-port strip flag ANDed with the permit mask.
- R11: Results become valid in the cycle after the deciding byte is accepted and stay unchanged until the next start of frame. A start-of-frame byte that is not also the last byte clears the valid flag one cycle later.
- R12: A start-of-frame byte always restarts parsing, even in the middle of a frame. Bytes after the deciding byte have no effect.
- R13: After reset the valid flag and all result outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte on in_data is accepted this cycle |
| in_sof | input | 1 | Accepted byte is the first one after the inner source MAC |
| in_eof | input | 1 | Accepted byte is the last byte of the frame |
| in_data | input | 8 | Stream byte |
| cfg_table | input | PORTS*SLOTS*38 | Per-port entries {valid, is_fine, label[23:0], cvid[11:0]}, entry p*SLOTS+s |
| cfg_strip | input | PORTS | Per-port strip-tag flag |
| res_valid | output | 1 | Results below are valid |
| res_class | output | 2 | 0 unknown, 1 VLAN, 2 fine, 3 malformed |
| res_label | output | 24 | Extracted label |
| res_xpri | output | 3 | Transport priority |
| res_xdei | output | 1 | Transport drop eligibility |
| res_npri | output | 3 | Native egress priority |
| res_ndei | output | 1 | Native egress drop eligibility |
| res_permit | output | PORTS | Per-port egress permit |
| res_strip | output | PORTS | Per-port strip of output tag |
| res_cvid | output | PORTS*12 | Per-port egress C-VLAN, port p at bits p*12 |

## Verification
The assertions assume that in_sof and in_eof are only meaningful while in_valid is high. They also assume that the configuration inputs stay fixed while a result is being held, since the hold checks compare the registered permit mask across cycles. The stimulus loads the port tables once after reset and never touches them again. It raises the frame markers only together with in_valid. It also exercises idle gaps inside a frame, a one-byte frame, and a frame cut short by a new start marker.

// File: rtl/ilf_pkg.sv
package ilf_pkg;

  localparam int VID_W   = 12;
  localparam int LABEL_W = 2 * VID_W;
  localparam int CVID_W  = VID_W;

  localparam logic [15:0] ET_VLAN = 16'h8100;
  localparam logic [15:0] ET_FINE = 16'h893B;

  typedef enum logic [1:0] {
    CLS_UNKNOWN = 2'd0,
    CLS_VLAN    = 2'd1,
    CLS_FINE    = 2'd2,
    CLS_BAD     = 2'd3
  } lbl_class_e;

  typedef struct packed {
    logic               valid;
    logic               fine;
    logic [LABEL_W-1:0] label;
    logic [CVID_W-1:0]  cvid;
  } lbl_entry_t;

  localparam int ENTRY_W = $bits(lbl_entry_t);

endpackage

// File: rtl/ilf_parser.sv
module ilf_parser
  import ilf_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic        in_sof,
  input  logic        in_eof,
  input  logic [7:0]  in_data,
  output logic        done,
  output lbl_class_e  cls,
  output logic [15:0] w_hi,
  output logic [15:0] w_lo
);

  logic       armed;
  logic [2:0] cnt;
  logic       fine_q;
  logic [7:0] r_b0;
  logic [7:0] r_b2;
  logic [7:0] r_b3;
  logic [7:0] r_b4;
  logic [7:0] r_b6;

  logic        active;
  logic [2:0]  pos;
  logic [15:0] et1;
  logic [15:0] et2;

  assign active = in_valid && (in_sof || armed);
  assign pos    = in_sof ? 3'd0 : cnt;
  assign et1    = {r_b0, in_data};
  assign et2    = {r_b4, in_data};
  assign w_hi   = (pos == 3'd3) ? {r_b2, in_data} : {r_b2, r_b3};
  assign w_lo   = {r_b6, in_data};

  // Decision for the byte being accepted this cycle.
  always_comb begin
    done = 1'b0;
    cls  = CLS_UNKNOWN;
    if (active) begin
      unique case (pos)
        3'd1: if (et1 != ET_VLAN && et1 != ET_FINE) begin
                done = 1'b1;
                cls  = CLS_UNKNOWN;
              end
        3'd3: if (!fine_q) begin
                done = 1'b1;
                cls  = CLS_VLAN;
              end
        3'd5: if (fine_q && et2 != ET_FINE) begin
                done = 1'b1;
                cls  = CLS_BAD;
              end
        3'd7: begin
                done = 1'b1;
                cls  = CLS_FINE;
              end
        default: ;
      endcase
      if (!done && in_eof) begin
        done = 1'b1;
        cls  = CLS_BAD;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed  <= 1'b0;
      cnt    <= 3'd0;
      fine_q <= 1'b0;
    end else if (active) begin
      if (done) begin
        armed <= 1'b0;
        cnt   <= 3'd0;
      end else begin
        armed <= 1'b1;
        cnt   <= pos + 3'd1;
      end
      if (pos == 3'd1) fine_q <= (et1 == ET_FINE);
    end
  end

  // Byte capture: data registers carry no reset.
  always_ff @(posedge clk) begin
    if (active) begin
      unique case (pos)
        3'd0: r_b0 <= in_data;
        3'd2: r_b2 <= in_data;
        3'd3: r_b3 <= in_data;
        3'd4: r_b4 <= in_data;
        3'd6: r_b6 <= in_data;
        default: ;
      endcase
    end
  end

  // R12: one decision per frame unless a new frame starts.
  p_single_done_r12: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done || (in_valid && in_sof)));

  // R4: an armed parser always sits inside the label area.
  p_cnt_inside_r4: assert property (@(posedge clk) disable iff (rst)
    armed |-> (cnt != 3'd0));

endmodule

// File: rtl/ilf_port_lookup.sv
module ilf_port_lookup
  import ilf_pkg::*;
#(
  parameter int SLOTS = 4
) (
  input  logic                     kind_fine,
  input  logic [LABEL_W-1:0]       key,
  input  logic [SLOTS*ENTRY_W-1:0] tbl,
  output logic                     hit,
  output logic [CVID_W-1:0]        cvid
);

  logic [SLOTS-1:0]  slot_hit;
  logic [CVID_W-1:0] slot_cvid [SLOTS];
  logic [CVID_W-1:0] mapped;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    lbl_entry_t ent;
    assign ent = tbl[s*ENTRY_W +: ENTRY_W];
    // Kinds must agree; VLAN entries compare the 12-bit ID only.
    assign slot_hit[s] = ent.valid && (ent.fine == kind_fine) &&
                         (kind_fine ? (ent.label == key)
                                    : (ent.label[VID_W-1:0] == key[VID_W-1:0]));
    assign slot_cvid[s] = ent.cvid;
  end

  always_comb begin
    mapped = '0;
    for (int s = SLOTS - 1; s >= 0; s--) begin
      if (slot_hit[s]) mapped = slot_cvid[s];
    end
    hit  = |slot_hit;
    cvid = '0;
    if (hit) cvid = kind_fine ? mapped : key[CVID_W-1:0];
  end

endmodule

// File: rtl/inner_label_filter.sv
module inner_label_filter
  import ilf_pkg::*;
#(
  parameter int PORTS = 4,
  parameter int SLOTS = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           in_valid,
  input  logic                           in_sof,
  input  logic                           in_eof,
  input  logic [7:0]                     in_data,
  input  logic [PORTS*SLOTS*ENTRY_W-1:0] cfg_table,
  input  logic [PORTS-1:0]               cfg_strip,
  output logic                           res_valid,
  output logic [1:0]                     res_class,
  output logic [LABEL_W-1:0]             res_label,
  output logic [2:0]                     res_xpri,
  output logic                           res_xdei,
  output logic [2:0]                     res_npri,
  output logic                           res_ndei,
  output logic [PORTS-1:0]               res_permit,
  output logic [PORTS-1:0]               res_strip,
  output logic [PORTS*CVID_W-1:0]        res_cvid
);

  localparam int PORT_TBL_W = SLOTS * ENTRY_W;

  logic               psr_done;
  lbl_class_e         psr_cls;
  logic [15:0]        psr_hi;
  logic [15:0]        psr_lo;
  logic               kind_fine;
  logic [LABEL_W-1:0] key;
  logic [PORTS-1:0]   lk_hit;
  logic [PORTS*CVID_W-1:0] lk_cvid;

  ilf_parser u_parser (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_sof   (in_sof),
    .in_eof   (in_eof),
    .in_data  (in_data),
    .done     (psr_done),
    .cls      (psr_cls),
    .w_hi     (psr_hi),
    .w_lo     (psr_lo)
  );

  assign kind_fine = (psr_cls == CLS_FINE);
  assign key = kind_fine ? {psr_hi[VID_W-1:0], psr_lo[VID_W-1:0]}
                         : {{VID_W{1'b0}}, psr_hi[VID_W-1:0]};

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    ilf_port_lookup #(.SLOTS(SLOTS)) u_lookup (
      .kind_fine (kind_fine),
      .key       (key),
      .tbl       (cfg_table[p*PORT_TBL_W +: PORT_TBL_W]),
      .hit       (lk_hit[p]),
      .cvid      (lk_cvid[p*CVID_W +: CVID_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid  <= 1'b0;
      res_class  <= CLS_UNKNOWN;
      res_label  <= '0;
      res_xpri   <= '0;
      res_xdei   <= 1'b0;
      res_npri   <= '0;
      res_ndei   <= 1'b0;
      res_permit <= '0;
      res_strip  <= '0;
      res_cvid   <= '0;
    end else if (psr_done) begin
      res_valid  <= 1'b1;
      res_class  <= psr_cls;
      res_label  <= '0;
      res_xpri   <= '0;
      res_xdei   <= 1'b0;
      res_npri   <= '0;
      res_ndei   <= 1'b0;
      res_permit <= '0;
      res_strip  <= '0;
      res_cvid   <= '0;
      if (psr_cls == CLS_VLAN || psr_cls == CLS_FINE) begin
        res_label  <= key;
        res_xpri   <= psr_hi[15:13];
        res_xdei   <= psr_hi[12];
        res_npri   <= kind_fine ? psr_lo[15:13] : psr_hi[15:13];
        res_ndei   <= kind_fine ? psr_lo[12] : psr_hi[12];
        res_permit <= lk_hit;
        res_strip  <= lk_hit & cfg_strip;
        res_cvid   <= lk_cvid;
      end
    end else if (in_valid && in_sof) begin
      res_valid <= 1'b0;
    end
  end

  // R11: a held result does not move until the next frame starts.
  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !(in_valid && in_sof)) |=>
      (res_valid && $stable(res_class) && $stable(res_permit) && $stable(res_label)));

  // R11: a fresh start marker withdraws the old result.
  p_sof_clear_r11: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_sof && !in_eof) |=> !res_valid);

  // R11: every parser decision shows up as a valid result.
  p_done_valid_r11: assert property (@(posedge clk) disable iff (rst)
    psr_done |=> res_valid);

  // R2: unknown frames are forwarded without any port decision.
  p_unknown_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_class == CLS_UNKNOWN) |-> (res_permit == '0 && res_strip == '0));

  // R3: malformed frames reach no port.
  p_bad_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_class == CLS_BAD) |-> (res_permit == '0 && res_cvid == '0));

endmodule

// File: tb/inner_label_filter_tb.sv
`timescale 1ns/1ps
module inner_label_filter_tb_top;

  localparam int P  = 4;
  localparam int S  = 4;
  localparam int EW = 38;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0] in_data = '0;
  logic [P*S*EW-1:0] cfg_table = '0;
  logic [P-1:0] cfg_strip = '0;
  logic res_valid, res_xdei, res_ndei;
  logic [1:0] res_class;
  logic [23:0] res_label;
  logic [2:0] res_xpri, res_npri;
  logic [P-1:0] res_permit, res_strip;
  logic [P*12-1:0] res_cvid;

  always #4 clk = ~clk;

  inner_label_filter #(.PORTS(P), .SLOTS(S)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
    .in_data(in_data), .cfg_table(cfg_table), .cfg_strip(cfg_strip),
    .res_valid(res_valid), .res_class(res_class), .res_label(res_label),
    .res_xpri(res_xpri), .res_xdei(res_xdei), .res_npri(res_npri), .res_ndei(res_ndei),
    .res_permit(res_permit), .res_strip(res_strip), .res_cvid(res_cvid)
  );

  typedef struct {
    string       tag;
    logic [1:0]  cls;
    logic [23:0] label;
    logic [2:0]  xp;
    logic        xd;
    logic [2:0]  np;
    logic        nd;
    logic [3:0]  permit;
    logic [3:0]  strip;
    logic [47:0] cvid;
  } exp_t;

  exp_t q[$];
  int n_chk = 0, n_err = 0;
  int sent = 0, taken = 0;
  logic [7:0] frm [16];

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic exp_t mk(string tag, logic [1:0] cls, logic [23:0] label,
                              logic [2:0] xp, logic xd, logic [2:0] np, logic nd,
                              logic [3:0] permit, logic [3:0] strip, logic [47:0] cvid);
    exp_t e;
    e.tag = tag; e.cls = cls; e.label = label; e.xp = xp; e.xd = xd;
    e.np = np; e.nd = nd; e.permit = permit; e.strip = strip; e.cvid = cvid;
    return e;
  endfunction

  task automatic ld(logic [127:0] v);
    for (int i = 0; i < 16; i++) frm[i] = v[127-8*i -: 8];
  endtask

  task automatic set_ent(int p, int s, logic v, logic f, logic [23:0] lab, logic [11:0] cv);
    cfg_table[(p*S+s)*EW +: EW] = {v, f, lab, cv};
  endtask

  // Monitor: compares each new result against the scoreboard head.
  always @(negedge clk) begin
    if (sent > taken && res_valid) begin
      exp_t e;
      e = q.pop_front();
      taken++;
      chk({e.tag, " R1 class"}, res_class, e.cls);
      chk({e.tag, " R6 label"}, res_label, e.label);
      chk({e.tag, " R5 transport pri/dei"}, {res_xpri, res_xdei}, {e.xp, e.xd});
      chk({e.tag, " R6 native pri/dei"}, {res_npri, res_ndei}, {e.np, e.nd});
      chk({e.tag, " R7 permit"}, res_permit, e.permit);
      chk({e.tag, " R10 strip"}, res_strip, e.strip);
      chk({e.tag, " R9 cvid"}, res_cvid, e.cvid);
    end
  end

  task automatic lat(int k, int dec);
    if (dec < 0) return;
    if (k == dec) chk("R11 valid after deciding byte", res_valid, 1);
    else if (k < dec) chk("R11 not valid before deciding byte", res_valid, 0);
  endtask

  // Driver: pushes the expectation, then plays the bytes.
  task automatic send(int n, int gap, int dec, bit push, exp_t e);
    if (push) q.push_back(e);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i > 0) lat(i - 1, dec);
      for (int g = 0; g < gap && i > 0; g++) begin
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1; in_data = frm[i];
      in_sof = (i == 0); in_eof = push && (i == n - 1);
      @(posedge clk);
      if (i == 0 && push) sent++;
    end
    @(negedge clk);
    lat(n - 1, dec);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    repeat (3) @(negedge clk);
    if (push) begin
      chk({e.tag, " R11 still valid"}, res_valid, 1);
      chk({e.tag, " R12 permit held"}, res_permit, e.permit);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    set_ent(0, 0, 1, 1, 24'h123456, 12'h00A);
    set_ent(0, 1, 1, 0, 24'h000123, 12'h000);
    set_ent(0, 2, 1, 1, 24'h123456, 12'h0FF);
    set_ent(1, 0, 1, 0, 24'h000123, 12'h000);
    set_ent(1, 1, 1, 0, 24'h000055, 12'h000);
    set_ent(2, 0, 1, 1, 24'hABCDEF, 12'h777);
    set_ent(2, 2, 1, 1, 24'h123456, 12'h0B0);
    set_ent(3, 0, 1, 1, 24'h123457, 12'h001);
    set_ent(3, 1, 0, 1, 24'h123456, 12'h999);
    set_ent(3, 3, 1, 1, 24'h000123, 12'h3C3);
    cfg_strip = 4'b0110;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R13 reset valid", res_valid, 0);
    chk("R13 reset outputs", {res_class, res_permit, res_strip, res_cvid, res_label}, 0);

    // R8 VLAN 0x123, pri 5, dei 1; fine entry 0x000123 on port 3 must not match (R7)
    ld(128'h8100B123_00000000_00000000_00000000);
    send(4, 0, 3, 1, mk("R8 vlan", 2'd1, 24'h000123, 3'd5, 1, 3'd5, 1, 4'b0011, 4'b0010, 48'h000_000_123_123));
    // R7 fine 0x123456, lowest slot on port 0 wins (R9), invalid slot on port 3 ignored
    ld(128'h893B6123_893BD456_00000000_00000000);
    send(8, 0, 7, 1, mk("R7 fine", 2'd2, 24'h123456, 3'd3, 0, 3'd6, 1, 4'b0101, 4'b0100, 48'h000_0B0_000_00A));
    // R7 fine (0x123.0x000): high part equals VLAN 0x123, no port qualifies
    ld(128'h893B0123_893B0000_00000000_00000000);
    send(8, 0, 7, 1, mk("R7 namespace", 2'd2, 24'h123000, 3'd0, 0, 3'd0, 0, 4'b0000, 4'b0000, 48'h0));
    // R12 VLAN 0x055 followed by fine-looking payload bytes
    ld(128'h81000055_893BFFFF_893BFFFF_00000000);
    send(12, 0, 3, 1, mk("R12 trailing bytes", 2'd1, 24'h000055, 3'd0, 0, 3'd0, 0, 4'b0010, 4'b0010, 48'h000_000_055_000));
    // R2 unknown Ethertype
    ld(128'h0800B123_893BD456_00000000_00000000);
    send(8, 0, 1, 1, mk("R2 unknown", 2'd0, 24'h0, 3'd0, 0, 3'd0, 0, 4'b0, 4'b0, 48'h0));
    // R3 second Ethertype wrong
    ld(128'h893B6123_8100D456_00000000_00000000);
    send(8, 0, 5, 1, mk("R3 bad second", 2'd3, 24'h0, 3'd0, 0, 3'd0, 0, 4'b0, 4'b0, 48'h0));
    // R4 fine frame cut after byte 4
    ld(128'h893B6123_89000000_00000000_00000000);
    send(5, 0, 4, 1, mk("R4 short fine", 2'd3, 24'h0, 3'd0, 0, 3'd0, 0, 4'b0, 4'b0, 48'h0));
    // R4 VLAN frame cut after byte 2
    ld(128'h8100B100_00000000_00000000_00000000);
    send(3, 0, 2, 1, mk("R4 short vlan", 2'd3, 24'h0, 3'd0, 0, 3'd0, 0, 4'b0, 4'b0, 48'h0));
    // R4 one-byte frame
    ld(128'h81000000_00000000_00000000_00000000);
    send(1, 0, 0, 1, mk("R4 one byte", 2'd3, 24'h0, 3'd0, 0, 3'd0, 0, 4'b0, 4'b0, 48'h0));
    // R11 fine 0xABCDEF with idle gaps between bytes
    ld(128'h893BFABC_893B0DEF_00000000_00000000);
    send(8, 2, 7, 1, mk("R11 gaps", 2'd2, 24'hABCDEF, 3'd7, 1, 3'd0, 0, 4'b0100, 4'b0100, 48'h000_777_000_000));
    // R12 partial frame abandoned by a new start marker
    ld(128'h893B6123_89000000_00000000_00000000);
    send(5, 0, -1, 0, mk("", 2'd0, 24'h0, 3'd0, 0, 3'd0, 0, 4'b0, 4'b0, 48'h0));
    ld(128'h8100B123_00000000_00000000_00000000);
    send(4, 0, 3, 1, mk("R12 restart", 2'd1, 24'h000123, 3'd5, 1, 3'd5, 1, 4'b0011, 4'b0010, 48'h000_000_123_123));
    // R7 fine 0x000123 only on the fine entry of port 3; R9 C-VLAN mapping
    ld(128'h893B0000_893B0123_00000000_00000000);
    send(8, 0, 7, 1, mk("R9 port3 map", 2'd2, 24'h000123, 3'd0, 0, 3'd0, 0, 4'b1000, 4'b0000, 48'h3C3_000_000_000));
    // R7 neighbouring label 0x123457 matches port 3 only
    ld(128'h893B0123_893B0457_00000000_00000000);
    send(8, 1, 7, 1, mk("R7 exact", 2'd2, 24'h123457, 3'd0, 0, 3'd0, 0, 4'b1000, 4'b0000, 48'h001_000_000_000));

    repeat (4) @(negedge clk);
    chk("R11 every result observed", q.size(), 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule